// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block places a direct-mapped, write-back cache between a word-addressed processor port and a main-memory port. Main memory holds 64K words behind a 16-bit word address; the cache keeps 128 lines of 16 words each, with a tag, a valid flag and a dirty flag for every line. A processor request selects one line from the middle address bits. It hits when that line is valid and its stored tag equals the upper address bits.

Hits are served at once. A write hit changes only the cached copy and marks the line dirty. On a miss the controller first copies a dirty victim line back to memory, one word per memory handshake. It then reads the new 16-word block in the same way, and finally completes the pending read or write from the freshly filled line. Both ports use a request/ready handshake. The requester holds its request and its address, direction and data steady until ready has been returned. Two counters report how many requests hit and how many missed.

Top module: `dmc_top`

## Requirements
- R1: After reset every line is invalid and clean, both counters read zero, and neither cpu_ready nor mem_req is asserted; the first access to any address misses.
- R2: The address splits into tag = bits 15:11, line index = bits 10:4 and word offset = bits 3:0. Memory block j (address bits 15:4) maps to line j mod 128, so two addresses with equal index and different tags evict each other.
- R3: A request to a valid line whose stored tag matches completes in the cycle it is presented, with cpu_ready high and no memory traffic. A read returns the cached word on cpu_rdata.
- R4: A write hit updates only the cached word and sets the line dirty. It issues no memory write, and the memory copy keeps its old value until the line is evicted.
- R5: A miss on a dirty line first writes all 16 words of the victim to memory. It writes them to address {stored tag, index, offset} in ascending offset order from 0 to 15, before any fill read.
- R6: A miss on an invalid or clean line performs no memory write. Every miss reads 16 words from {request tag, index, offset} in ascending offset order from 0 to 15.
- R7: After the fill the line is valid, holds the new tag and is clean. The pending read returns the requested word from the filled data. A pending write stores its word and marks the line dirty, so that a later eviction writes it back.
- R8: hit_count rises by one for each request that hits and miss_count by one for each request that misses, counted once per request.
- R9: On the memory side mem_req, mem_we, mem_addr and mem_wdata stay steady until mem_ready is seen. Each mem_ready cycle moves exactly one word.
- R10: cpu_ready is high for exactly one cycle per request, and only while cpu_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | One-cycle completion strobe |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | 1 = write back a word, 0 = fill read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_rdata | input | 16 | Fill data, valid with mem_ready |
| mem_ready | input | 1 | One-cycle completion strobe from memory |
| hit_count | output | 16 | Requests that hit |
| miss_count | output | 16 | Requests that missed |

## Verification
Accesses are chosen to exercise each path: cold misses, repeat hits in the same line, and write hits followed by reads. Conflicting tags on one index evict both dirty and clean victims. Write misses are later evicted, and the lowest and highest lines are used. A dirty eviction shows whether write-back happens at all and in the right order, a clean eviction shows that no write is issued, and a write hit that is read back while memory is inspected separates write-back from write-through. A bench-side model of tags and data predicts every returned word, every memory address sequence and both counters.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_RESP  = 2'd3
    } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             load,
    input  logic [TAG_W-1:0] load_tag,
    input  logic             dirty_set,
    output logic [TAG_W-1:0] tag,
    output logic             valid,
    output logic             dirty
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (load) tag_q[idx] <= load_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (load) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (dirty_set) dirty_q[idx] <= 1'b1;
        end
    end

    assign tag   = tag_q[idx];
    assign valid = valid_q[idx];
    assign dirty = dirty_q[idx];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_a_off,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [OFF_W-1:0]  rd_b_off,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int DEPTH = 1 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) word_q[{idx, wr_off}] <= wr_data;
    end

    assign rd_a_data = word_q[{idx, rd_a_off}];
    assign rd_b_data = word_q[{idx, rd_b_off}];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int OFF_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             line_valid,
    input  logic             line_dirty,
    input  logic             mem_ready,
    output logic             cpu_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [OFF_W-1:0] word_off,
    output logic             wr_en,
    output logic             wr_from_mem,
    output logic             tag_load,
    output logic             dirty_set,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam logic [OFF_W-1:0] OFF_LAST = '1;
    localparam logic [OFF_W-1:0] OFF_ONE  = 1;
    localparam logic [CNT_W-1:0] CNT_ONE  = 1;

    typedef struct packed {
        dmc_state_e       state;
        logic [OFF_W-1:0] off;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
    } ctrl_t;

    ctrl_t q, d;
    logic  hit;

    assign hit = line_valid && (line_tag == req_tag);

    always_comb begin
        d           = q;
        cpu_ready   = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        wr_en       = 1'b0;
        wr_from_mem = 1'b0;
        tag_load    = 1'b0;
        dirty_set   = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        cpu_ready = 1'b1;
                        d.hits    = q.hits + CNT_ONE;
                        if (cpu_we) begin
                            wr_en     = 1'b1;
                            dirty_set = 1'b1;
                        end
                    end else begin
                        d.misses = q.misses + CNT_ONE;
                        d.off    = '0;
                        d.state  = (line_valid && line_dirty) ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    d.off = q.off + OFF_ONE;
                    if (q.off == OFF_LAST) d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    wr_en       = 1'b1;
                    wr_from_mem = 1'b1;
                    d.off       = q.off + OFF_ONE;
                    if (q.off == OFF_LAST) begin
                        tag_load = 1'b1;
                        d.state  = ST_RESP;
                    end
                end
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                if (cpu_we) begin
                    wr_en     = 1'b1;
                    dirty_set = 1'b1;
                end
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_off   = q.off;
    assign hit_count  = q.hits;
    assign miss_count = q.misses;

endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [TAG_W-1:0]  req_tag, line_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off, word_off, wr_off;
    logic [DATA_W-1:0] wr_data;
    logic              line_valid, line_dirty;
    logic              wr_en, wr_from_mem, tag_load, dirty_set;

    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_off = cpu_addr[OFF_W-1:0];

    assign wr_off   = wr_from_mem ? word_off  : req_off;
    assign wr_data  = wr_from_mem ? mem_rdata : cpu_wdata;
    assign mem_addr = {(mem_we ? line_tag : req_tag), req_idx, word_off};

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (req_idx),
        .load      (tag_load),
        .load_tag  (req_tag),
        .dirty_set (dirty_set),
        .tag       (line_tag),
        .valid     (line_valid),
        .dirty     (line_dirty)
    );

    dmc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .idx       (req_idx),
        .wr_en     (wr_en),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .rd_a_off  (req_off),
        .rd_a_data (cpu_rdata),
        .rd_b_off  (word_off),
        .rd_b_data (mem_wdata)
    );

    dmc_ctrl #(.TAG_W(TAG_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .req_tag     (req_tag),
        .line_tag    (line_tag),
        .line_valid  (line_valid),
        .line_dirty  (line_dirty),
        .mem_ready   (mem_ready),
        .cpu_ready   (cpu_ready),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .word_off    (word_off),
        .wr_en       (wr_en),
        .wr_from_mem (wr_from_mem),
        .tag_load    (tag_load),
        .dirty_set   (dirty_set),
        .hit_count   (hit_count),
        .miss_count  (miss_count)
    );

endmodule

// File: rtl/dmc_chk.sv
module dmc_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    localparam logic [OFF_W-1:0] LAST = '1;
    localparam logic [OFF_W-1:0] ONE  = 1;
    localparam logic [CNT_W-1:0] C1   = 1;

    logic [OFF_W-1:0] off;
    assign off = mem_addr[OFF_W-1:0];

    // R10
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    // R3
    ready_quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready && off != LAST)
        |=> (mem_req && mem_we && off == $past(off) + ONE));

    // R5
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready && off == LAST)
        |=> (mem_req && !mem_we && off == '0));

    // R6
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready && off != LAST)
        |=> (mem_req && !mem_we && off == $past(off) + ONE));

    // R7
    fill_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready && off == LAST) |=> (cpu_ready && !mem_req));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + C1)) &&
        ((miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + C1)));

    // R8
    cnt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));

endmodule

bind dmc_top dmc_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_dmc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_ready  (cpu_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/tb_dmc_top.sv
module tb_dmc_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam int WATCHDOG   = 60000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [15:0] hit_count, miss_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmc_top dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        we;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    logic [15:0] mem_store [logic [15:0]];
    logic [15:0] ref_data  [logic [15:0]];
    logic [15:0] wr_log[$];
    logic [15:0] rd_log[$];
    int          mem_wr_cnt = 0;

    logic [4:0] btag [128];
    bit         bval [128];
    bit         bdty [128];
    int         exp_hits = 0;
    int         exp_misses = 0;

    function automatic logic [15:0] init_val(input logic [15:0] a);
        return (a * 16'd7) ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] mem_peek(input logic [15:0] a);
        if (mem_store.exists(a)) return mem_store[a];
        return init_val(a);
    endfunction

    function automatic logic [15:0] ref_peek(input logic [15:0] a);
        if (ref_data.exists(a)) return ref_data[a];
        return init_val(a);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: one word per handshake after MEM_LAT cycles
    initial begin
        int w;
        w = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                w = 0;
            end else if (rst_n && mem_req) begin
                w++;
                if (w >= MEM_LAT) begin
                    mem_ready = 1'b1;
                    if (mem_we) begin
                        mem_store[mem_addr] = mem_wdata;
                        wr_log.push_back(mem_addr);
                        mem_wr_cnt++;
                    end else begin
                        mem_rdata = mem_peek(mem_addr);
                        rd_log.push_back(mem_addr);
                    end
                end
            end
        end
    end

    // scoreboard monitor
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && cpu_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10", "ready without pending request", 1, 0);
                end else begin
                    it = sb_q.pop_front();
                    if (!it.we)
                        check(cpu_rdata == it.exp, it.tag, "read data", cpu_rdata, it.exp);
                end
            end
        end
    end

    task automatic access(input logic we, input logic [15:0] a, input logic [15:0] wd);
        logic [6:0] idx;
        logic [4:0] tg, old;
        bit         hit, dty;
        int         cyc;
        sb_item_t   it;
        idx = a[10:4];
        tg  = a[15:11];
        old = btag[idx];
        hit = bval[idx] && (btag[idx] == tg);
        dty = bval[idx] && bdty[idx] && !hit;
        if (hit) exp_hits++;
        else     exp_misses++;
        if (!hit) begin
            btag[idx] = tg;
            bval[idx] = 1'b1;
            bdty[idx] = 1'b0;
        end
        if (we) bdty[idx] = 1'b1;
        it.we  = we;
        it.exp = ref_peek(a);
        it.tag = hit ? "R3" : "R7";
        sb_q.push_back(it);
        if (we) ref_data[a] = wd;
        wr_log.delete();
        rd_log.delete();

        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        forever begin
            #2;
            if (cpu_ready) break;
            @(negedge clk);
            cyc++;
            if (cyc > 5000) break;
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #2;
        check(cpu_ready == 1'b0, "R10", "ready pulse longer than one cycle", cpu_ready, 0);
        check(hit_count == exp_hits[15:0], "R8", "hit_count", hit_count, exp_hits);
        check(miss_count == exp_misses[15:0], "R8", "miss_count", miss_count, exp_misses);
        if (hit) begin
            check(cyc == 0, "R3", "hit latency", cyc, 0);
            check(wr_log.size() == 0 && rd_log.size() == 0, "R4",
                  "memory traffic on hit", wr_log.size() + rd_log.size(), 0);
        end else begin
            check(wr_log.size() == (dty ? 16 : 0), "R5", "write-back word count",
                  wr_log.size(), dty ? 16 : 0);
            if (wr_log.size() == 16)
                for (int k = 0; k < 16; k++)
                    check(wr_log[k] == {old, idx, k[3:0]}, "R5", "write-back address",
                          wr_log[k], {old, idx, k[3:0]});
            check(rd_log.size() == 16, "R6", "fill word count", rd_log.size(), 16);
            if (rd_log.size() == 16)
                for (int k = 0; k < 16; k++)
                    check(rd_log[k] == {tg, idx, k[3:0]}, "R6", "fill address",
                          rd_log[k], {tg, idx, k[3:0]});
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int wr_before;
        for (int i = 0; i < 128; i++) begin
            bval[i] = 1'b0; bdty[i] = 1'b0; btag[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R1 reset state
        check(cpu_ready == 1'b0, "R1", "cpu_ready after reset", cpu_ready, 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        check(hit_count == 16'd0, "R1", "hit_count after reset", hit_count, 0);
        check(miss_count == 16'd0, "R1", "miss_count after reset", miss_count, 0);

        // R1/R6 cold read miss: tag 0, line 0x12, offset 3
        access(1'b0, 16'h0123, 16'h0);
        // R3 hit in same line
        access(1'b0, 16'h0128, 16'h0);
        // R4 write hit, memory keeps old copy
        wr_before = mem_wr_cnt;
        access(1'b1, 16'h0123, 16'hBEEF);
        check(mem_wr_cnt == wr_before, "R4", "memory writes on write hit", mem_wr_cnt, wr_before);
        check(mem_peek(16'h0123) == init_val(16'h0123), "R4", "memory word after write hit",
              mem_peek(16'h0123), init_val(16'h0123));
        access(1'b0, 16'h0123, 16'h0);
        // R2/R5 conflicting tag 3, same line: dirty eviction
        access(1'b0, 16'h1927, 16'h0);
        check(mem_peek(16'h0123) == 16'hBEEF, "R5", "written-back word",
              mem_peek(16'h0123), 16'hBEEF);
        check(mem_peek(16'h0128) == init_val(16'h0128), "R5", "untouched written-back word",
              mem_peek(16'h0128), init_val(16'h0128));
        // R7 filled line was clean: evicting it writes nothing
        access(1'b0, 16'h0123, 16'h0);
        // R7 write miss then read back
        access(1'b1, 16'h0C0F, 16'h1234);
        access(1'b0, 16'h0C0F, 16'h0);
        access(1'b0, 16'h0C00, 16'h0);
        // R7 write-miss line is dirty: evict with tag 2
        access(1'b0, 16'h1402, 16'h0);
        check(mem_peek(16'h0C0F) == 16'h1234, "R7", "write-miss word written back",
              mem_peek(16'h0C0F), 16'h1234);
        // R2 line index extremes: line 127 and line 0
        access(1'b1, 16'hFFFF, 16'h7777);
        access(1'b0, 16'hFFF0, 16'h0);
        access(1'b0, 16'h0000, 16'h0);
        access(1'b0, 16'h7FF3, 16'h0);
        check(mem_peek(16'hFFFF) == 16'h7777, "R5", "line 127 written back",
              mem_peek(16'hFFFF), 16'h7777);
        access(1'b0, 16'hFFFF, 16'h0);
        access(1'b0, 16'h0005, 16'h0);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R10", "requests left without completion", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule